// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. Its 32-bit counter counts up. It advances only on ticks of a slow timer-clock enable, and an optional power-of-two divider can thin those ticks. Software arms and disarms the watchdog by writing two key words in a fixed order. It services the watchdog by writing a new trigger value, which reloads the counter from a software-set load value. If the counter wraps past its all-ones value while the watchdog is armed, the block drives a reset pulse and latches a sticky reset-cause flag.

Each writable register models a hand-off into the slow timer domain. An accepted write is parked in a per-register holding slot, and a status bit shows it as pending. The write takes effect on the second slow tick after it was accepted. While a register's write is pending, further writes to that register are dropped. Control and load writes that land while the watchdog is armed are discarded when they complete.

The key sequencer has four states:
- `ST_HALTED`: disarmed.
- `ST_START_ARMED`: the first start word has been seen.
- `ST_RUNNING`: armed.
- `ST_STOP_ARMED`: armed, and the first stop word has been seen.

Its transitions are:
- HALTED to START_ARMED on word 0xBBBB.
- START_ARMED to RUNNING on 0x4444.
- START_ARMED back to HALTED on any other word.
- RUNNING to STOP_ARMED on 0xAAAA.
- STOP_ARMED to HALTED on 0x5555.
- STOP_ARMED back to RUNNING on any other word.
- In HALTED and RUNNING, every other word leaves the state unchanged.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the counter reads 0, the pending register (address 5) reads 0, `reset_out` and `reset_cause` are low, and the watchdog is disarmed.
- R2: Committing 0xBBBB and then 0x4444 to the key register (address 4) arms the watchdog. The counter then advances on slow ticks.
- R3: While armed, committing 0xAAAA and then 0x5555 to the key register disarms the watchdog. The counter then holds its value across slow ticks.
- R4: If any other word follows a first key word, the sequence is cancelled and the state is unchanged. A later second key word on its own has no effect.
- R5: The pending register shows control at bit 0, load at bit 2, trigger at bit 3 and key at bit 4. A bit is set from the cycle after a write is accepted until the second slow tick after that write. A write to a register whose bit is set is ignored.
- R6: In the control register (address 0), bit 5 enables the divider and bits 4:2 hold the divider exponent P. With the divider enabled, the counter advances once every 2^(P+1) slow ticks. With it disabled, the counter advances on every slow tick.
- R7: Committing a trigger value (address 3) that differs from the last committed trigger value reloads the counter from the load register (address 1). Committing the same value again does not reload.
- R8: Control and load writes that complete while the watchdog is armed leave those registers unchanged.
- R9: When an armed counter advances from 0xFFFFFFFF, it reloads from the load register. `reset_out` is then high for exactly 16 clocks, and `reset_cause` sets and stays set until `rst_n`.
- R10: The revision register (address 6) returns the 8-bit revision parameter in bits 7:0 and zero above.
- R11: The counter register (address 2) returns the live counter value, which rises by one per counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable marking each slow timer-clock tick |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| reset_out | output | 1 | Reset pulse that follows a counter overflow |
| reset_cause | output | 1 | Sticky flag set by a watchdog reset |

## Verification
On every cycle, the assertions check the following:
- A pending slot stays pending, with its held word frozen, until it commits.
- The sequencer changes between armed and disarmed only on the matching second key word.
- A disarmed counter without a reload stays put.
- An overflow yields the reload value, the reset pulse and the flag, and the flag never clears.
- Configuration stays frozen while the watchdog is armed.

Only the bench scenarios can show the rest: the exact divider rate for a given exponent, the 16-clock pulse length, trigger reload against a repeated value, cancelled key sequences, and the counting that happens during the ticks spent completing writes.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd3;
    localparam logic [ADDR_W-1:0] A_KEY   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd5;
    localparam logic [ADDR_W-1:0] A_REV   = 3'd6;

    localparam int NUM_SLOTS = 4;
    localparam int SL_CTRL   = 0;
    localparam int SL_LOAD   = 1;
    localparam int SL_TRIG   = 2;
    localparam int SL_KEY    = 3;

    localparam logic [DATA_W-1:0] KEY_ON_1  = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_ON_2  = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_OFF_1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_OFF_2 = 32'h0000_5555;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_003C;
    localparam int CTRL_PRE_EN  = 5;
    localparam int CTRL_PTV_LSB = 2;
    localparam int PTV_W        = 3;

    typedef enum logic [1:0] {
        ST_HALTED      = 2'd0,
        ST_START_ARMED = 2'd1,
        ST_RUNNING     = 2'd2,
        ST_STOP_ARMED  = 2'd3
    } wdt_state_e;

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            SL_CTRL: return A_CTRL;
            SL_LOAD: return A_LOAD;
            SL_TRIG: return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

    function automatic int pend_bit(input int idx);
        case (idx)
            SL_CTRL: return 0;
            SL_LOAD: return 2;
            SL_TRIG: return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int DW    = 32,
    parameter int TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          slow_tick,
    output logic          pending,
    output logic          commit,
    output logic [DW-1:0] held_data
);

    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic [TW-1:0] tick_cnt;

    always_comb begin
        commit = pending && slow_tick && (tick_cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            tick_cnt  <= '0;
            held_data <= '0;
        end else if (!pending) begin
            if (wr_req) begin
                pending   <= 1'b1;
                tick_cnt  <= '0;
                held_data <= wr_data;
            end
        end else if (slow_tick) begin
            if (tick_cnt == LAST) begin
                pending <= 1'b0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // R5: a pending write is not lost or replaced before it commits
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !commit) |=> (pending && $stable(held_data)));

    // R5: an idle slot only turns pending because a write request arrived
    p_pend_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !wr_req) |=> !pending);

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import keyed_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_commit,
    input  logic [DATA_W-1:0] key_word,
    output logic              running
);

    wdt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (key_commit) begin
            unique case (state_q)
                ST_HALTED:      if (key_word == KEY_ON_1)  state_d = ST_START_ARMED;
                ST_START_ARMED: state_d = (key_word == KEY_ON_2)  ? ST_RUNNING : ST_HALTED;
                ST_RUNNING:     if (key_word == KEY_OFF_1) state_d = ST_STOP_ARMED;
                ST_STOP_ARMED:  state_d = (key_word == KEY_OFF_2) ? ST_HALTED  : ST_RUNNING;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUNNING, ST_STOP_ARMED: running = 1'b1;
            ST_HALTED, ST_START_ARMED: running = 1'b0;
        endcase
    end

    // R2: the watchdog arms only on a committed second start word
    p_arm_only_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(key_commit && key_word == KEY_ON_2)) |=> !running);

    // R3: the watchdog disarms only on a committed second stop word
    p_disarm_only_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(key_commit && key_word == KEY_OFF_2)) |=> running);

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int CNT_W      = 32,
    parameter int PRE_W      = 8,
    parameter int PTV_W      = 3,
    parameter int RST_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             running,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             reset_out,
    output logic             reset_cause
);

    localparam int RST_W = $clog2(RST_CYCLES + 1);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_limit;
    logic [RST_W-1:0] rst_cnt;
    logic             count_tick;
    logic             ovf_evt;

    always_comb begin
        pre_limit  = (PRE_ONE << (int'(ptv) + 1)) - PRE_ONE;
        count_tick = slow_tick && running && (!pre_en || (pre_cnt == pre_limit));
        ovf_evt    = count_tick && (&count) && !reload;
        reset_out  = (rst_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!running || !pre_en) begin
            pre_cnt <= '0;
        end else if (slow_tick) begin
            pre_cnt <= (pre_cnt == pre_limit) ? '0 : pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (reload || ovf_evt) begin
            count <= load_val;
        end else if (count_tick) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cnt     <= '0;
            reset_cause <= 1'b0;
        end else begin
            if (ovf_evt) begin
                rst_cnt     <= RST_W'(RST_CYCLES);
                reset_cause <= 1'b1;
            end else if (rst_cnt != '0) begin
                rst_cnt <= rst_cnt - 1'b1;
            end
        end
    end

    // R9: overflow reloads, raises the reset pulse and the cause flag
    p_ovf_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (reset_out && reset_cause && count == $past(load_val)));

    // R9: the cause flag never clears outside reset
    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_cause |=> reset_cause);

    // R3: a disarmed counter holds unless reloaded
    p_frozen_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload) |=> $stable(count));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter logic [7:0] REV          = 8'h3A,
    parameter int         COMMIT_TICKS = 2,
    parameter int         RST_CYCLES   = 16,
    parameter int         PRE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_out,
    output logic              reset_cause
);

    logic [NUM_SLOTS-1:0] slot_req;
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_commit;
    logic [DATA_W-1:0]    slot_data [NUM_SLOTS];

    logic [DATA_W-1:0] ctrl_reg;
    logic [DATA_W-1:0] load_reg;
    logic [DATA_W-1:0] trig_last;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] pend_word;
    logic              running;
    logic              trig_reload;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_req[g] = bus_we && (bus_addr == slot_addr(g));

        wdt_post_slot #(
            .DW    (DATA_W),
            .TICKS (COMMIT_TICKS)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_req    (slot_req[g]),
            .wr_data   (bus_wdata),
            .slow_tick (slow_tick),
            .pending   (slot_pend[g]),
            .commit    (slot_commit[g]),
            .held_data (slot_data[g])
        );
    end

    wdt_key_fsm u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_commit (slot_commit[SL_KEY]),
        .key_word   (slot_data[SL_KEY]),
        .running    (running)
    );

    always_comb begin
        trig_reload = slot_commit[SL_TRIG] && (slot_data[SL_TRIG] != trig_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_reg  <= '0;
            load_reg  <= '0;
            trig_last <= '0;
        end else begin
            if (slot_commit[SL_CTRL] && !running) ctrl_reg <= slot_data[SL_CTRL] & CTRL_MASK;
            if (slot_commit[SL_LOAD] && !running) load_reg <= slot_data[SL_LOAD];
            if (trig_reload)                      trig_last <= slot_data[SL_TRIG];
        end
    end

    wdt_count_core #(
        .CNT_W      (DATA_W),
        .PRE_W      (PRE_W),
        .PTV_W      (PTV_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .running     (running),
        .pre_en      (ctrl_reg[CTRL_PRE_EN]),
        .ptv         (ctrl_reg[CTRL_PTV_LSB +: PTV_W]),
        .reload      (trig_reload),
        .load_val    (load_reg),
        .count       (count),
        .reset_out   (reset_out),
        .reset_cause (reset_cause)
    );

    always_comb begin
        pend_word = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            pend_word[pend_bit(i)] = slot_pend[i];
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_reg;
            A_LOAD:  bus_rdata = load_reg;
            A_COUNT: bus_rdata = count;
            A_TRIG:  bus_rdata = trig_last;
            A_KEY:   bus_rdata = {{(DATA_W-1){1'b0}}, running};
            A_PEND:  bus_rdata = pend_word;
            A_REV:   bus_rdata = {{(DATA_W-8){1'b0}}, REV};
            default: bus_rdata = '0;
        endcase
    end

    // R8: configuration cannot change while the watchdog is armed
    p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(ctrl_reg) && $stable(load_reg)));

endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        reset_out;
    logic        reset_cause;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    keyed_wdt u_keyed_wdt (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .reset_out   (reset_out),
        .reset_cause (reset_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads and compares them with the bus
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #2;
            check(sb_q[0].tag, bus_rdata, sb_q[0].exp);
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic wr_done(input logic [2:0] a, input logic [31:0] d);
        bus_write(a, d);
        tick(2);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 revision
        expect_reg(3'd2, 32'h0, "R1 count after reset");
        expect_reg(3'd5, 32'h0, "R1 pend after reset");
        expect_reg(3'd4, 32'h0, "R1 disarmed after reset");
        check("R1 reset_out low", {31'd0, reset_out}, 32'd0);
        check("R1 reset_cause low", {31'd0, reset_cause}, 32'd0);
        expect_reg(3'd6, 32'h3A, "R10 revision");

        // R5 pending bits and dropped write
        bus_write(3'd1, 32'h100);
        expect_reg(3'd5, 32'h4, "R5 load pend bit2");
        bus_write(3'd1, 32'h123);
        tick(1);
        expect_reg(3'd5, 32'h4, "R5 still pending after one tick");
        tick(1);
        expect_reg(3'd5, 32'h0, "R5 cleared after two ticks");
        expect_reg(3'd1, 32'h100, "R5 write while pending ignored");
        bus_write(3'd0, 32'h0);
        expect_reg(3'd5, 32'h1, "R5 ctrl pend bit0");
        tick(2);
        bus_write(3'd3, 32'h1);
        expect_reg(3'd5, 32'h8, "R5 trig pend bit3");
        tick(2);
        expect_reg(3'd2, 32'h100, "R7 trigger reloads counter");
        bus_write(3'd4, 32'hBBBB);
        expect_reg(3'd5, 32'h10, "R5 key pend bit4");
        tick(2);

        // R2 start, R11 counting, R6 undivided
        wr_done(3'd4, 32'h4444);
        expect_reg(3'd4, 32'h1, "R2 armed");
        expect_reg(3'd2, 32'h100, "R2 count at arm");
        tick(5);
        expect_reg(3'd2, 32'h105, "R11 R6 one step per tick");

        // R7 same value vs new value
        wr_done(3'd3, 32'h1);
        expect_reg(3'd2, 32'h107, "R7 same trigger no reload");
        wr_done(3'd3, 32'hFFFF_FFFE);
        expect_reg(3'd2, 32'h100, "R7 new trigger reloads");

        // R8 config locked while armed
        wr_done(3'd1, 32'h5);
        expect_reg(3'd1, 32'h100, "R8 load locked");
        wr_done(3'd0, 32'h24);
        expect_reg(3'd0, 32'h0, "R8 ctrl locked");
        expect_reg(3'd2, 32'h104, "R8 count kept running");

        // R4 cancelled stop sequence
        wr_done(3'd4, 32'hAAAA);
        wr_done(3'd4, 32'h1234);
        wr_done(3'd4, 32'h5555);
        expect_reg(3'd2, 32'h10A, "R4 stop cancelled still counting");

        // R3 stop
        wr_done(3'd4, 32'hAAAA);
        wr_done(3'd4, 32'h5555);
        expect_reg(3'd4, 32'h0, "R3 disarmed");
        tick(3);
        expect_reg(3'd2, 32'h10E, "R3 count holds");

        // R4 cancelled start sequence
        wr_done(3'd4, 32'hBBBB);
        wr_done(3'd4, 32'h1111);
        wr_done(3'd4, 32'h4444);
        tick(3);
        expect_reg(3'd4, 32'h0, "R4 start cancelled");
        expect_reg(3'd2, 32'h10E, "R4 count unchanged");

        // R6 divider P=1 -> every 4 ticks
        wr_done(3'd0, 32'h24);
        expect_reg(3'd0, 32'h24, "R6 ctrl accepted while off");
        wr_done(3'd4, 32'hBBBB);
        wr_done(3'd4, 32'h4444);
        tick(8);
        expect_reg(3'd2, 32'h110, "R6 two steps in eight ticks");
        tick(3);
        expect_reg(3'd2, 32'h110, "R6 no step before fourth tick");
        tick(1);
        expect_reg(3'd2, 32'h111, "R6 step on fourth tick");

        // R9 overflow
        wr_done(3'd4, 32'hAAAA);
        wr_done(3'd4, 32'h5555);
        wr_done(3'd0, 32'h0);
        wr_done(3'd1, 32'hFFFF_FFFD);
        wr_done(3'd3, 32'h1);
        expect_reg(3'd2, 32'hFFFF_FFFD, "R7 reload near top");
        wr_done(3'd4, 32'hBBBB);
        wr_done(3'd4, 32'h4444);
        tick(2);
        expect_reg(3'd2, 32'hFFFF_FFFF, "R11 count at top");
        check("R9 no reset before wrap", {31'd0, reset_out}, 32'd0);
        tick(1);
        n = 0;
        while (reset_out && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R9 pulse length", n, 32'd16);
        check("R9 cause set", {31'd0, reset_cause}, 32'd1);
        expect_reg(3'd2, 32'hFFFF_FFFD, "R9 reload after wrap");
        wr_done(3'd4, 32'hAAAA);
        wr_done(3'd4, 32'h5555);
        tick(4);
        check("R9 cause sticky", {31'd0, reset_cause}, 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule